// File: doc/BRIEF.md
# Per-Pixel Alpha and Depth Test Stage

This block decides the fate of one fragment per clock. The rasterizer supplies the fragment's alpha and depth. The memory side supplies the depth already stored at that pixel and the stored destination-alpha bit. A 64-bit test configuration word says which tests run and how.

The block applies three tests:
- an alpha test against an 8-bit reference;
- a destination-alpha test on the stored alpha bit;
- a depth test against the stored depth.

It returns a survive/kill flag and three separate write enables, for frame-buffer RGB, frame-buffer alpha and depth. When the alpha test fails, a selectable fail mode can still let the fragment update part of its target. A failing depth or destination-alpha test always kills the fragment. A global depth-write mask input can suppress depth writes on any fragment.

The decision is registered once. Results appear one cycle after the fragment is presented, qualified by a valid output.

Top module: `pxt_frag_test`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by one clock. The decision outputs in a cycle describe the fragment presented one cycle earlier. Synchronous reset clears `out_valid` and all decision outputs.
- R2: The alpha test is enabled by cfg bit 0. It compares `frag_alpha` (left operand) against the reference in cfg[11:4], using the comparison in cfg[3:1]: 0 never, 1 always, 2 less, 3 less-or-equal, 4 equal, 5 greater-or-equal, 6 greater, 7 not-equal. When bit 0 is 0, the alpha test passes.
- R3: A fragment that passes all tests drives `out_pass`, `out_we_rgb` and `out_we_alpha` high, and drives `out_we_z` high unless R8 applies.
- R4: Alpha failure with fail mode cfg[13:12] = 0 kills the fragment: all four decision outputs are low.
- R5: Alpha failure with fail mode 1 keeps the fragment with RGB and alpha writes and no depth write.
- R6: Alpha failure with fail mode 2 keeps the fragment with only the depth write (subject to R8).
- R7: Alpha failure with fail mode 3 keeps the fragment with only the RGB write.
- R8: When `zwrite_mask` is high, `out_we_z` is low for that fragment. `out_pass` and the color enables are unaffected.
- R9: The destination-alpha test is enabled by cfg bit 14. It kills the fragment when `dst_abit` differs from cfg bit 15.
- R10: The depth test is enabled by cfg bit 16. It uses the comparison in cfg[18:17]: 0 never, 1 always, 2 `frag_z` >= `dst_z`, 3 `frag_z` > `dst_z`. A failure kills the fragment whatever the alpha fail mode. When bit 16 is 0, the depth test passes.
- R11: While `out_valid` is low, all four decision outputs are low. cfg bits 63:19 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Fragment present this cycle |
| frag_alpha | input | 8 | Fragment alpha |
| frag_z | input | ZW (24) | Fragment depth |
| dst_z | input | ZW (24) | Stored depth at the pixel |
| dst_abit | input | 1 | Stored destination-alpha bit |
| cfg | input | 64 | Test configuration word |
| zwrite_mask | input | 1 | Global depth-write suppression |
| out_valid | output | 1 | Decision valid |
| out_pass | output | 1 | Fragment survives |
| out_we_rgb | output | 1 | Write frame-buffer RGB |
| out_we_alpha | output | 1 | Write frame-buffer alpha |
| out_we_z | output | 1 | Write depth buffer |

## Verification
Every result of this block is due exactly one clock after its fragment: valid, pass and the three enables all come from the single output register. The bench drives each fragment on a falling edge. It then reads the outputs on the next falling edge, after exactly one rising edge, before driving the next fragment. That edge also serves R1's valid-delay and idle checks, so no check races the capture edge.

// File: rtl/pxt_pkg.sv
package pxt_pkg;

    typedef enum logic [2:0] {
        ACMP_NEVER  = 3'd0,
        ACMP_ALWAYS = 3'd1,
        ACMP_LT     = 3'd2,
        ACMP_LE     = 3'd3,
        ACMP_EQ     = 3'd4,
        ACMP_GE     = 3'd5,
        ACMP_GT     = 3'd6,
        ACMP_NE     = 3'd7
    } acmp_e;

    typedef enum logic [1:0] {
        AF_DROP       = 2'd0,
        AF_COLOR_ALL  = 2'd1,
        AF_DEPTH_ONLY = 2'd2,
        AF_RGB_ONLY   = 2'd3
    } afail_e;

    typedef enum logic [1:0] {
        ZCMP_NEVER  = 2'd0,
        ZCMP_ALWAYS = 2'd1,
        ZCMP_GE     = 2'd2,
        ZCMP_GT     = 2'd3
    } zcmp_e;

    typedef struct packed {
        logic   a_en;
        acmp_e  a_fn;
        logic [7:0] a_ref;
        afail_e a_fail;
        logic   da_en;
        logic   da_sel;
        logic   z_en;
        zcmp_e  z_fn;
    } test_cfg_t;

    typedef struct packed {
        logic pass;
        logic we_rgb;
        logic we_a;
        logic we_z;
    } wr_ctl_t;

    localparam wr_ctl_t CTL_KILL = '{pass: 1'b0, we_rgb: 1'b0, we_a: 1'b0, we_z: 1'b0};

    function automatic test_cfg_t cfg_fields(input logic [18:0] w);
        test_cfg_t c;
        c.a_en   = w[0];
        c.a_fn   = acmp_e'(w[3:1]);
        c.a_ref  = w[11:4];
        c.a_fail = afail_e'(w[13:12]);
        c.da_en  = w[14];
        c.da_sel = w[15];
        c.z_en   = w[16];
        c.z_fn   = zcmp_e'(w[18:17]);
        return c;
    endfunction

endpackage

// File: rtl/pxt_alpha_cmp.sv
module pxt_alpha_cmp
    import pxt_pkg::*;
(
    input  logic       en,
    input  acmp_e      fn,
    input  logic [7:0] val,
    input  logic [7:0] a_ref,
    output logic       ok
);
    logic hit;

    always_comb begin
        unique case (fn)
            ACMP_NEVER:  hit = 1'b0;
            ACMP_ALWAYS: hit = 1'b1;
            ACMP_LT:     hit = (val <  a_ref);
            ACMP_LE:     hit = (val <= a_ref);
            ACMP_EQ:     hit = (val == a_ref);
            ACMP_GE:     hit = (val >= a_ref);
            ACMP_GT:     hit = (val >  a_ref);
            default:     hit = (val != a_ref);
        endcase
        ok = !en || hit;
    end
endmodule

// File: rtl/pxt_depth_cmp.sv
module pxt_depth_cmp
    import pxt_pkg::*;
#(
    parameter int ZW = 24
) (
    input  logic          en,
    input  zcmp_e         fn,
    input  logic [ZW-1:0] z_new,
    input  logic [ZW-1:0] z_old,
    output logic          ok
);
    logic hit;

    always_comb begin
        unique case (fn)
            ZCMP_NEVER:  hit = 1'b0;
            ZCMP_ALWAYS: hit = 1'b1;
            ZCMP_GE:     hit = (z_new >= z_old);
            default:     hit = (z_new >  z_old);
        endcase
        ok = !en || hit;
    end
endmodule

// File: rtl/pxt_write_resolve.sv
module pxt_write_resolve
    import pxt_pkg::*;
(
    input  logic    a_ok,
    input  logic    da_ok,
    input  logic    z_ok,
    input  afail_e  fail_mode,
    input  logic    zmask,
    output wr_ctl_t ctl
);
    always_comb begin
        ctl = CTL_KILL;
        if (da_ok && z_ok) begin
            if (a_ok) begin
                ctl = '{pass: 1'b1, we_rgb: 1'b1, we_a: 1'b1, we_z: !zmask};
            end else begin
                unique case (fail_mode)
                    AF_DROP:       ctl = CTL_KILL;
                    AF_COLOR_ALL:  ctl = '{pass: 1'b1, we_rgb: 1'b1, we_a: 1'b1, we_z: 1'b0};
                    AF_DEPTH_ONLY: ctl = '{pass: 1'b1, we_rgb: 1'b0, we_a: 1'b0, we_z: !zmask};
                    default:       ctl = '{pass: 1'b1, we_rgb: 1'b1, we_a: 1'b0, we_z: 1'b0};
                endcase
            end
        end
    end
endmodule

// File: rtl/pxt_frag_test.sv
module pxt_frag_test
    import pxt_pkg::*;
#(
    parameter int ZW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [7:0]    frag_alpha,
    input  logic [ZW-1:0] frag_z,
    input  logic [ZW-1:0] dst_z,
    input  logic          dst_abit,
    input  logic [63:0]   cfg,
    input  logic          zwrite_mask,
    output logic          out_valid,
    output logic          out_pass,
    output logic          out_we_rgb,
    output logic          out_we_alpha,
    output logic          out_we_z
);
    test_cfg_t tc;
    logic      unused_cfg_hi;
    logic      a_ok, da_ok, z_ok;
    wr_ctl_t   ctl_d, ctl_q;
    logic      vld_q;

    assign tc            = cfg_fields(cfg[18:0]);
    assign unused_cfg_hi = ^cfg[63:19];
    assign da_ok         = !tc.da_en || (dst_abit == tc.da_sel);

    pxt_alpha_cmp u_alpha (
        .en    (tc.a_en),
        .fn    (tc.a_fn),
        .val   (frag_alpha),
        .a_ref (tc.a_ref),
        .ok    (a_ok)
    );

    pxt_depth_cmp #(.ZW(ZW)) u_depth (
        .en    (tc.z_en),
        .fn    (tc.z_fn),
        .z_new (frag_z),
        .z_old (dst_z),
        .ok    (z_ok)
    );

    pxt_write_resolve u_resolve (
        .a_ok      (a_ok),
        .da_ok     (da_ok),
        .z_ok      (z_ok),
        .fail_mode (tc.a_fail),
        .zmask     (zwrite_mask),
        .ctl       (ctl_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            ctl_q <= CTL_KILL;
        end else begin
            vld_q <= in_valid;
            ctl_q <= in_valid ? ctl_d : CTL_KILL;
        end
    end

    assign out_valid    = vld_q;
    assign out_pass     = ctl_q.pass;
    assign out_we_rgb   = ctl_q.we_rgb;
    assign out_we_alpha = ctl_q.we_a;
    assign out_we_z     = ctl_q.we_z;

    // R1
    valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !(out_pass || out_we_rgb || out_we_alpha || out_we_z));
    // R8
    zmask_block_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && zwrite_mask) |=> !out_we_z);
    // R9
    dalpha_kill_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cfg[14] && (dst_abit != cfg[15])) |=> !out_pass);
    // R10
    depth_never_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cfg[16] && cfg[18:17] == 2'd0) |=> !out_pass);
    // R4
    afail_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cfg[0] && cfg[3:1] == 3'd0 && cfg[13:12] == 2'd0) |=> !out_pass);
    // R3
    alpha_needs_rgb_chk: assert property (@(posedge clk) disable iff (rst)
        out_we_alpha |-> (out_we_rgb && out_pass));
endmodule

// File: tb/tb_pxt_frag_test.sv
module tb_pxt_frag_test;
    localparam int ZW = 24;
    localparam time CLK_PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [7:0]    frag_alpha;
    logic [ZW-1:0] frag_z, dst_z;
    logic          dst_abit;
    logic [63:0]   cfg;
    logic          zwrite_mask;
    logic          out_valid, out_pass, out_we_rgb, out_we_alpha, out_we_z;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pxt_frag_test #(.ZW(ZW)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .frag_alpha(frag_alpha),
        .frag_z(frag_z), .dst_z(dst_z), .dst_abit(dst_abit), .cfg(cfg),
        .zwrite_mask(zwrite_mask), .out_valid(out_valid), .out_pass(out_pass),
        .out_we_rgb(out_we_rgb), .out_we_alpha(out_we_alpha), .out_we_z(out_we_z)
    );

    // returns {valid, pass, rgb, alpha, z}
    function automatic logic [4:0] model(input logic v, input logic [7:0] a,
        input logic [ZW-1:0] fz, input logic [ZW-1:0] dz, input logic dab,
        input logic [63:0] c, input logic zm);
        logic aok, dok, zok, hit;
        logic [7:0] r;
        r = c[11:4];
        case (c[3:1])
            3'd0: hit = 0; 3'd1: hit = 1; 3'd2: hit = a < r; 3'd3: hit = a <= r;
            3'd4: hit = a == r; 3'd5: hit = a >= r; 3'd6: hit = a > r;
            default: hit = a != r;
        endcase
        aok = !c[0] || hit;
        dok = !c[14] || (dab == c[15]);
        case (c[18:17])
            2'd0: zok = 0; 2'd1: zok = 1; 2'd2: zok = fz >= dz; default: zok = fz > dz;
        endcase
        if (!c[16]) zok = 1;
        if (!v) return 5'b0;
        if (!(dok && zok)) return 5'b10000;
        if (aok) return {4'b1111, !zm};
        case (c[13:12])
            2'd0: return 5'b10000;
            2'd1: return 5'b11110;
            2'd2: return {4'b1100, !zm};
            default: return 5'b11100;
        endcase
    endfunction

    function automatic string classify(input logic v, input logic [7:0] a,
        input logic [ZW-1:0] fz, input logic [ZW-1:0] dz, input logic dab,
        input logic [63:0] c, input logic zm);
        logic [4:0] e;
        logic [4:0] e_alpha_on;
        e = model(v, a, fz, dz, dab, c, zm);
        e_alpha_on = model(v, a, fz, dz, dab, {c[63:1], 1'b0}, zm);
        if (!v) return "R11";
        if (c[14] && dab != c[15]) return "R9";
        if (c[16] && e == 5'b10000 && c[18:17] != 2'd1) return "R10";
        if (e != e_alpha_on) begin
            case (c[13:12])
                2'd0: return "R4"; 2'd1: return "R5"; 2'd2: return "R6"; default: return "R7";
            endcase
        end
        if (zm) return "R8";
        return "R3";
    endfunction

    task automatic check(input string tag, input logic [4:0] exp_v);
        logic [4:0] act;
        act = {out_valid, out_pass, out_we_rgb, out_we_alpha, out_we_z};
        n_chk++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s: {valid,pass,rgb,a,z} actual=%b expected=%b", tag, act, exp_v);
        end
    endtask

    // drive on falling edge, check on next falling edge (one posedge later)
    task automatic apply(input string tag, input logic v, input logic [7:0] a,
        input logic [ZW-1:0] fz, input logic [ZW-1:0] dz, input logic dab,
        input logic [63:0] c, input logic zm);
        logic [4:0] e;
        in_valid = v; frag_alpha = a; frag_z = fz; dst_z = dz;
        dst_abit = dab; cfg = c; zwrite_mask = zm;
        e = model(v, a, fz, dz, dab, c, zm);
        @(negedge clk);
        check(tag, e);
    endtask

    function automatic logic [63:0] mk(input logic aen, input logic [2:0] afn,
        input logic [7:0] r, input logic [1:0] fm, input logic den, input logic dsel,
        input logic zen, input logic [1:0] zfn);
        return {45'd0, zfn, zen, dsel, den, fm, r, afn, aen};
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst = 1; in_valid = 0; frag_alpha = 0; frag_z = 0; dst_z = 0;
        dst_abit = 0; cfg = 0; zwrite_mask = 0;
        @(negedge clk); @(negedge clk);
        check("R1", 5'b0);   // reset state
        rst = 0;

        // R3 all tests off: full write
        apply("R3", 1, 8'h10, 24'd5, 24'd9, 0, mk(0,0,0,0,0,0,0,0), 0);
        // R2 alpha compare codes at boundaries (ref 0x40), fail mode 0 exposes result
        apply("R2", 1, 8'h3F, 0, 0, 0, mk(1,3'd2,8'h40,0,0,0,0,0), 0);
        apply("R2", 1, 8'h40, 0, 0, 0, mk(1,3'd2,8'h40,0,0,0,0,0), 0);
        apply("R2", 1, 8'h40, 0, 0, 0, mk(1,3'd3,8'h40,0,0,0,0,0), 0);
        apply("R2", 1, 8'h40, 0, 0, 0, mk(1,3'd4,8'h40,0,0,0,0,0), 0);
        apply("R2", 1, 8'h41, 0, 0, 0, mk(1,3'd4,8'h40,0,0,0,0,0), 0);
        apply("R2", 1, 8'h40, 0, 0, 0, mk(1,3'd5,8'h40,0,0,0,0,0), 0);
        apply("R2", 1, 8'h40, 0, 0, 0, mk(1,3'd6,8'h40,0,0,0,0,0), 0);
        apply("R2", 1, 8'h40, 0, 0, 0, mk(1,3'd7,8'h40,0,0,0,0,0), 0);
        apply("R2", 1, 8'h00, 0, 0, 0, mk(1,3'd1,8'h40,0,0,0,0,0), 0);
        // R4..R7 fail modes with never
        apply("R4", 1, 8'h80, 0, 0, 0, mk(1,3'd0,8'h00,2'd0,0,0,0,0), 0);
        apply("R5", 1, 8'h80, 0, 0, 0, mk(1,3'd0,8'h00,2'd1,0,0,0,0), 0);
        apply("R6", 1, 8'h80, 0, 0, 0, mk(1,3'd0,8'h00,2'd2,0,0,0,0), 0);
        apply("R6", 1, 8'h80, 0, 0, 0, mk(1,3'd0,8'h00,2'd2,0,0,0,0), 1);
        apply("R7", 1, 8'h80, 0, 0, 0, mk(1,3'd0,8'h00,2'd3,0,0,0,0), 0);
        // R8 mask
        apply("R8", 1, 8'h80, 0, 0, 0, mk(0,0,0,0,0,0,0,0), 1);
        // R9 destination alpha
        apply("R9", 1, 0, 0, 0, 1, mk(0,0,0,0,1,0,0,0), 0);
        apply("R9", 1, 0, 0, 0, 1, mk(0,0,0,0,1,1,0,0), 0);
        // R10 depth: equal with GE passes, with GT fails; fail beats alpha mode
        apply("R10", 1, 0, 24'd100, 24'd100, 0, mk(0,0,0,0,0,0,1,2'd2), 0);
        apply("R10", 1, 0, 24'd100, 24'd100, 0, mk(0,0,0,0,0,0,1,2'd3), 0);
        apply("R10", 1, 0, 24'd7, 24'd9, 0, mk(1,3'd0,0,2'd1,0,0,1,2'd2), 0);
        apply("R10", 1, 0, 24'd7, 24'd9, 0, mk(0,0,0,0,0,0,0,2'd0), 0);
        // R11 high config bits ignored, idle outputs low
        apply("R11", 1, 8'h80, 0, 0, 0, {45'h1FFF_FFFF_FFFF, 19'd0}, 0);
        apply("R11", 0, 8'h80, 0, 0, 0, mk(0,0,0,0,0,0,0,0), 0);
        // R1 valid after a gap
        apply("R1", 1, 8'h01, 0, 0, 0, 64'd0, 0);

        for (int i = 0; i < 3000; i++) begin
            logic [63:0] c;
            logic [7:0] a;
            logic [ZW-1:0] fz, dz;
            logic v, dab, zm;
            c  = {$urandom, $urandom};
            a  = 8'($urandom);
            if ($urandom_range(3) == 0) a = c[11:4];
            dz = ZW'($urandom);
            fz = ZW'($urandom);
            if ($urandom_range(3) == 0) fz = dz;
            v   = ($urandom_range(7) != 0);
            dab = 1'($urandom);
            zm  = ($urandom_range(3) == 0);
            apply(classify(v, a, fz, dz, dab, c, zm), v, a, fz, dz, dab, c, zm);
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule